// File: doc/BRIEF.md
# Scanline Line-Compare Unit

This block counts display scanlines one dot clock at a time and compares a line value against a register that the CPU can write. Its results are a coincidence flag for the status register, a level coincidence interrupt line and a one-cycle interrupt request pulse. The compared value is kept separate from the visible line counter. For a few cycles around each line change the compared value is invalid, and during those cycles the interrupt line holds its previous level.

A mode input picks one of two timing variants, monochrome or colour. The variants behave differently while the comparison is invalid. They also step through the last line of the frame on different schedules. On the last line the visible counter and the compared value wrap to zero in several timed phases, and the compared value briefly matches the last line number before it settles at zero. In colour mode, a register write made shortly after the settle point first produces one extra comparison against the last line number, using the old register value.

Top module: `lyc_compare_unit`

## Requirements
- R1: While `lcdOn` is high, the dot position advances by one every cycle. A line lasts `LINE_LEN` cycles and lines run from 0 to `NUM_LINES-1`, then wrap to 0. `ly` shows the line number, except for the last-line timings of R5 and R6.
- R2: At every clock edge with a valid compared value, `coinFlag` becomes 1 if the compared value equals the effective compare register and 0 if it does not. The result is visible in the cycle after the evaluated one.
- R3: On lines 1 to `NUM_LINES-2`, the compared value is invalid for the first `CMP_GAP` cycles of the line and equals the line number after that. On line 0 it is 0 and valid from the first cycle.
- R4: While the compared value is invalid, the coincidence line keeps its level. `coinFlag` is cleared in monochrome mode (`colourMode`=0) and held unchanged in colour mode (`colourMode`=1).
- R5: Monochrome last line, by dot: 0-5 invalid with `ly` equal to the last line number; 6-7 compared value equals the last line number while `ly` reads 0; from dot 8 on `ly` reads 0.
- R6: Colour last line, by dot: 0-3 invalid; 4-7 compared value equals the last line number. `ly` keeps the last line number through dot 7 and reads 0 from dot 8.
- R7: In both modes, dots 8-11 of the last line are invalid. From dot 12 to the end of the line the compared value is 0.
- R8: A write to the compare register takes effect in its own cycle, and that cycle's evaluation uses the new value. This includes the cycle in which the compared value changes.
- R9: In colour mode, a write during dots 12-23 of the last line first evaluates the last line number against the old register value, then 0 against the new one. A rise in either step raises `irqPulse`; the flag and line end at the second result. In monochrome mode no such extra step occurs.
- R10: `irqLine` equals the coincidence line ANDed with `lycIrqEn`. `irqPulse` is high for one cycle after the coincidence line rises while `lycIrqEn` is 1.
- R11: With `rstN` low, or in the cycle after `lcdOn` is sampled low, `ly`, `coinFlag`, `irqLine` and `irqPulse` are 0. The compare register resets only on `rstN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Active-low reset |
| lcdOn | input | 1 | Display enable; low stops and clears the counters |
| colourMode | input | 1 | 0 = monochrome timing, 1 = colour timing |
| lycWrEn | input | 1 | Compare register write strobe |
| lycWrData | input | 8 | Compare register write value |
| lycIrqEn | input | 1 | Coincidence interrupt enable |
| ly | output | 8 | Current visible line |
| coinFlag | output | 1 | Coincidence status flag |
| irqLine | output | 1 | Gated coincidence level |
| irqPulse | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the unit with `LINE_LEN`=40, `NUM_LINES`=10 and `CMP_GAP`=4, so the last line is 9 and a whole frame takes 400 cycles. At that size the bench can cover, in a few thousand cycles, every line-start invalid window, the full last-line phase sequence in both modes, and the wrap into line 0. It can also place writes at exact dots inside and outside the colour conflict window.

// File: rtl/lyc_cmp_pkg.sv
package lyc_cmp_pkg;
  localparam int LY_W = 8;

  // Last-line phase boundaries (dot indices, exclusive ends)
  localparam int MONO_INV1_END = 6;
  localparam int COL_INV1_END  = 4;
  localparam int LAST_CMP_END  = 8;
  localparam int INV2_END      = 12;
  localparam int CONFLICT_LEN  = 12;

  typedef struct packed {
    logic            run;
    logic            cmpValid;
    logic [LY_W-1:0] cmpVal;
    logic            conflictWin;
    logic            holdFlag;
  } cmpStrobe_t;
endpackage

// File: rtl/lyc_line_ctrl.sv
module lyc_line_ctrl
  import lyc_cmp_pkg::*;
#(
  parameter int LINE_LEN  = 456,
  parameter int NUM_LINES = 154,
  parameter int CMP_GAP   = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lcdOn,
  input  logic            colourMode,
  output logic [LY_W-1:0] ly,
  output cmpStrobe_t      strb
);
  localparam int DOT_W  = $clog2(LINE_LEN);
  localparam int LINE_W = $clog2(NUM_LINES);
  localparam logic [DOT_W-1:0]  DOT_MAX   = DOT_W'(LINE_LEN - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(NUM_LINES - 1);
  localparam logic [DOT_W-1:0]  GAP_END   = DOT_W'(CMP_GAP);
  localparam logic [DOT_W-1:0]  MONO_I1   = DOT_W'(MONO_INV1_END);
  localparam logic [DOT_W-1:0]  COL_I1    = DOT_W'(COL_INV1_END);
  localparam logic [DOT_W-1:0]  LAST_END  = DOT_W'(LAST_CMP_END);
  localparam logic [DOT_W-1:0]  I2_END    = DOT_W'(INV2_END);
  localparam logic [DOT_W-1:0]  WIN_END   = DOT_W'(INV2_END + CONFLICT_LEN);
  localparam logic [LY_W-1:0]   LAST_LY   = LY_W'(NUM_LINES - 1);

  logic [DOT_W-1:0]  dot;
  logic [LINE_W-1:0] line;
  logic              onLast;
  logic [DOT_W-1:0]  inv1End;

  always_ff @(posedge clk) begin
    if (!rstN || !lcdOn) begin
      dot  <= '0;
      line <= '0;
    end else if (dot == DOT_MAX) begin
      dot  <= '0;
      line <= (line == LINE_LAST) ? '0 : line + 1'b1;
    end else begin
      dot <= dot + 1'b1;
    end
  end

  assign onLast  = (line == LINE_LAST);
  assign inv1End = colourMode ? COL_I1 : MONO_I1;

  always_comb begin
    strb.run         = lcdOn;
    strb.holdFlag    = colourMode;
    strb.conflictWin = colourMode && onLast && (dot >= I2_END) && (dot < WIN_END);
    strb.cmpValid    = 1'b1;
    strb.cmpVal      = '0;
    ly               = LY_W'(line);
    if (onLast) begin
      if (colourMode) ly = (dot < LAST_END) ? LAST_LY : '0;
      else            ly = (dot < MONO_I1) ? LAST_LY : '0;
      if (dot < inv1End) begin
        strb.cmpValid = 1'b0;
      end else if (dot < LAST_END) begin
        strb.cmpVal = LAST_LY;
      end else if (dot < I2_END) begin
        strb.cmpValid = 1'b0;
      end
    end else if (line != '0) begin
      strb.cmpValid = (dot >= GAP_END);
      strb.cmpVal   = LY_W'(line);
    end
  end
endmodule

// File: rtl/lyc_cmp_datapath.sv
module lyc_cmp_datapath
  import lyc_cmp_pkg::*;
#(
  parameter int NUM_LINES = 154
) (
  input  logic            clk,
  input  logic            rstN,
  input  cmpStrobe_t      strb,
  input  logic            lycWrEn,
  input  logic [LY_W-1:0] lycWrData,
  input  logic            lycIrqEn,
  output logic            coinFlag,
  output logic            lycLine,
  output logic            irqPulse
);
  localparam logic [LY_W-1:0] LAST_LY = LY_W'(NUM_LINES - 1);

  logic [LY_W-1:0] lycReg;
  logic [LY_W-1:0] effLyc;
  logic            matchOld;
  logic            matchNew;
  logic            nextLine;
  logic            nextFlag;
  logic            rise;

  assign effLyc   = lycWrEn ? lycWrData : lycReg;
  assign matchOld = (LAST_LY == lycReg);
  assign matchNew = (strb.cmpVal == effLyc);

  always_comb begin
    nextLine = lycLine;
    nextFlag = coinFlag;
    rise     = 1'b0;
    if (strb.cmpValid && strb.conflictWin && lycWrEn) begin
      nextLine = matchNew;
      nextFlag = matchNew;
      rise     = (!lycLine && matchOld) || (!matchOld && matchNew);
    end else if (strb.cmpValid) begin
      nextLine = matchNew;
      nextFlag = matchNew;
      rise     = !lycLine && matchNew;
    end else if (!strb.holdFlag) begin
      nextFlag = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lycReg   <= '0;
      lycLine  <= 1'b0;
      coinFlag <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      if (lycWrEn) lycReg <= lycWrData;
      if (!strb.run) begin
        lycLine  <= 1'b0;
        coinFlag <= 1'b0;
        irqPulse <= 1'b0;
      end else begin
        lycLine  <= nextLine;
        coinFlag <= nextFlag;
        irqPulse <= rise && lycIrqEn;
      end
    end
  end
endmodule

// File: rtl/lyc_compare_unit.sv
module lyc_compare_unit
  import lyc_cmp_pkg::*;
#(
  parameter int LINE_LEN  = 456,
  parameter int NUM_LINES = 154,
  parameter int CMP_GAP   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lcdOn,
  input  logic       colourMode,
  input  logic       lycWrEn,
  input  logic [7:0] lycWrData,
  input  logic       lycIrqEn,
  output logic [7:0] ly,
  output logic       coinFlag,
  output logic       irqLine,
  output logic       irqPulse
);
  cmpStrobe_t strb;
  logic       lycLine;

  lyc_line_ctrl #(
    .LINE_LEN (LINE_LEN),
    .NUM_LINES(NUM_LINES),
    .CMP_GAP  (CMP_GAP)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .lcdOn     (lcdOn),
    .colourMode(colourMode),
    .ly        (ly),
    .strb      (strb)
  );

  lyc_cmp_datapath #(
    .NUM_LINES(NUM_LINES)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lycWrEn  (lycWrEn),
    .lycWrData(lycWrData),
    .lycIrqEn (lycIrqEn),
    .coinFlag (coinFlag),
    .lycLine  (lycLine),
    .irqPulse (irqPulse)
  );

  assign irqLine = lycLine & lycIrqEn;
endmodule

// File: rtl/lyc_compare_chk.sv
module lyc_compare_chk
  import lyc_cmp_pkg::*;
#(
  parameter int NUM_LINES = 154
) (
  input logic       clk,
  input logic       rstN,
  input logic       lcdOn,
  input logic       colourMode,
  input logic       lycIrqEn,
  input logic [7:0] ly,
  input logic       coinFlag,
  input logic       irqLine,
  input logic       irqPulse,
  input logic       lycLine,
  input cmpStrobe_t strb
);
  // R1
  ly_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ly <= 8'(NUM_LINES - 1));

  // R11
  off_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lcdOn |=> (ly == 8'd0) && !coinFlag && !irqLine && !irqPulse);

  // R4
  mono_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lcdOn && !colourMode && !strb.cmpValid) |=> !coinFlag);

  // R4
  colour_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lcdOn && colourMode && !strb.cmpValid) |=> $stable(coinFlag));

  // R4
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lcdOn && !strb.cmpValid) |=> $stable(lycLine));

  // R10
  pulse_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(lycIrqEn) && $past(strb.cmpValid));
endmodule

bind lyc_compare_unit lyc_compare_chk #(.NUM_LINES(NUM_LINES)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .lcdOn     (lcdOn),
  .colourMode(colourMode),
  .lycIrqEn  (lycIrqEn),
  .ly        (ly),
  .coinFlag  (coinFlag),
  .irqLine   (irqLine),
  .irqPulse  (irqPulse),
  .lycLine   (lycLine),
  .strb      (strb)
);

// File: tb/sim_lyc_compare_unit.sv
module sim_lyc_compare_unit;
  localparam int LEN   = 40;
  localparam int LINES = 10;
  localparam int GAP   = 4;
  localparam int FRAME = LEN * LINES;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lcdOn = 1'b0;
  logic colourMode = 1'b0;
  logic lycWrEn = 1'b0;
  logic [7:0] lycWrData = 8'd0;
  logic lycIrqEn = 1'b0;
  logic [7:0] ly;
  logic coinFlag, irqLine, irqPulse;

  int tick = 0;
  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  always @(posedge clk) tick <= lcdOn ? tick + 1 : 0;

  lyc_compare_unit #(.LINE_LEN(LEN), .NUM_LINES(LINES), .CMP_GAP(GAP)) u0 (
    .clk(clk), .rstN(rstN), .lcdOn(lcdOn), .colourMode(colourMode),
    .lycWrEn(lycWrEn), .lycWrData(lycWrData), .lycIrqEn(lycIrqEn),
    .ly(ly), .coinFlag(coinFlag), .irqLine(irqLine), .irqPulse(irqPulse)
  );

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", req, act, exp, tick);
    end
  endtask

  task automatic goTo(int ln, int dt);
    while ((tick % FRAME) != ln * LEN + dt) @(negedge clk);
  endtask

  task automatic writeLyc(int v);
    lycWrEn = 1'b1;
    lycWrData = 8'(v);
    @(negedge clk);
    lycWrEn = 1'b0;
  endtask

  task automatic restart(bit mode, int lyc, bit en);
    lcdOn = 1'b0;
    @(negedge clk);
    writeLyc(lyc);
    colourMode = mode;
    lycIrqEn = en;
    @(negedge clk);
    lcdOn = 1'b1;
  endtask

  task automatic testReset();
    chk("R11 ly", ly, 0);
    chk("R11 flag", coinFlag, 0);
    chk("R11 irqLine", irqLine, 0);
    chk("R11 pulse", irqPulse, 0);
  endtask

  task automatic testCount();
    restart(0, 200, 0);
    goTo(2, 39); chk("R1 ly end of line 2", ly, 2);
    @(negedge clk); chk("R1 ly line 3", ly, 3);
    goTo(0, 0); @(negedge clk); chk("R1 wrap to 0", ly, 0);
  endtask

  task automatic testMonoMatch();
    restart(0, 3, 1);
    goTo(3, 4); chk("R3 invalid gap flag", coinFlag, 0);
    @(negedge clk); chk("R2 match flag", coinFlag, 1);
    chk("R10 pulse on rise", irqPulse, 1);
    chk("R10 irqLine", irqLine, 1);
    @(negedge clk); chk("R10 pulse one cycle", irqPulse, 0);
    goTo(4, 1); chk("R4 mono flag cleared", coinFlag, 0);
    chk("R4 line held", irqLine, 1);
    goTo(4, 5); chk("R2 mismatch clears line", irqLine, 0);
  endtask

  task automatic testColourHold();
    restart(1, 3, 1);
    goTo(4, 3); chk("R4 colour flag held", coinFlag, 1);
    goTo(4, 5); chk("R2 colour mismatch", coinFlag, 0);
  endtask

  task automatic testMonoLast();
    restart(0, 9, 1);
    goTo(9, 5); chk("R5 ly last", ly, 9);
    @(negedge clk); chk("R5 ly 0 at dot 6", ly, 0);
    chk("R5 flag before", coinFlag, 0);
    @(negedge clk); chk("R5 match last", coinFlag, 1);
    chk("R5 pulse", irqPulse, 1);
    goTo(9, 9); chk("R7 mono flag cleared", coinFlag, 0);
    chk("R7 line held", irqLine, 1);
    goTo(9, 12); chk("R7 still held dot 12", irqLine, 1);
    @(negedge clk); chk("R7 compare 0", irqLine, 0);
  endtask

  task automatic testColourLast();
    restart(1, 9, 1);
    goTo(9, 4); chk("R6 flag before", coinFlag, 0);
    @(negedge clk); chk("R6 match last", coinFlag, 1);
    chk("R6 pulse", irqPulse, 1);
    goTo(9, 7); chk("R6 ly last at dot 7", ly, 9);
    @(negedge clk); chk("R6 ly 0 at dot 8", ly, 0);
    goTo(9, 12); chk("R7 colour flag held", coinFlag, 1);
    @(negedge clk); chk("R7 colour compare 0", coinFlag, 0);
  endtask

  task automatic testZero();
    restart(0, 0, 0);
    goTo(9, 13); chk("R7 zero match", coinFlag, 1);
    goTo(0, 5); chk("R3 line 0 valid", coinFlag, 1);
    goTo(1, 1); chk("R3 line 1 invalid", coinFlag, 0);
  endtask

  task automatic testConflict();
    restart(1, 9, 1);
    goTo(9, 15); writeLyc(5);
    chk("R9 colour extra pulse", irqPulse, 1);
    chk("R9 final flag", coinFlag, 0);
    restart(0, 9, 1);
    goTo(9, 15); writeLyc(5);
    chk("R9 mono no pulse", irqPulse, 0);
    restart(1, 9, 1);
    goTo(9, 30); writeLyc(5);
    chk("R9 outside window no pulse", irqPulse, 0);
    restart(1, 3, 1);
    goTo(9, 20); writeLyc(0);
    chk("R9 new value pulse", irqPulse, 1);
    chk("R9 new value flag", coinFlag, 1);
  endtask

  task automatic testWrite();
    restart(0, 200, 1);
    goTo(5, 20); writeLyc(5);
    chk("R8 immediate flag", coinFlag, 1);
    chk("R8 immediate pulse", irqPulse, 1);
    restart(1, 200, 1);
    goTo(6, 4); writeLyc(6);
    chk("R8 change cycle uses new", coinFlag, 1);
  endtask

  task automatic testGate();
    restart(0, 3, 0);
    goTo(3, 5); chk("R10 flag set", coinFlag, 1);
    chk("R10 gated line", irqLine, 0);
    chk("R10 gated pulse", irqPulse, 0);
    goTo(3, 10); lycIrqEn = 1'b1; #1;
    chk("R10 line follows enable", irqLine, 1);
    @(negedge clk); chk("R10 no pulse on enable", irqPulse, 0);
    lcdOn = 1'b0;
    @(negedge clk);
    chk("R11 off ly", ly, 0);
    chk("R11 off flag", coinFlag, 0);
    chk("R11 off line", irqLine, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testCount();
    testMonoMatch();
    testColourHold();
    testMonoLast();
    testColourLast();
    testZero();
    testConflict();
    testWrite();
    testGate();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule